// File: doc/BRIEF.md
# Null-Access Error Logger

This block sits beside an on-chip interconnect and watches for transactions that decode to no target. When such a null access is flagged, the block records a two-word header and four data words that describe the failing transaction: address, route, access attributes, privilege identity and byte count. It then raises a level interrupt.

Software reaches the block through a 32-bit register port. Through this port it reads the log, programs the destination identifier stamped into the header, and enables or disables the interrupt with separate write-one-to-set and write-one-to-clear registers. When it has finished servicing the interrupt, it writes the end-of-interrupt register.

While an error is pending, the log is frozen. No later null access replaces it until software acknowledges the pending one. Only the first error is kept; there is no queue.

Top module: `nullacc_err_logger`

## Requirements
- R1: The revision register at offset 0x00 always reads 0x6600_3102: scheme 1 in bits 31:30, unit 2 in 29:28, module ID 0x600 in 27:16, RTL revision 6 in 15:11, major 1 in 10:8, custom 0 in 7:6 and minor 2 in 5:0. Writes to it have no effect.
- R2: After reset, every register other than the revision reads zero and `irq` is low.
- R3: The destination register at offset 0x04 stores write-data bits 7:0. Its bits 31:8 read as zero.
- R4: A null access arriving while no error is pending is captured on that clock edge.
  - Header word 0 (0x24) reads type 7 in bits 31:24, zero in 23:8 and the destination value in 7:0.
  - Data word 0 (0x2C) holds address bits 31:0.
  - Data word 1 (0x30) holds address bits 47:32 in its bits 15:0.
  - Data word 2 (0x34) holds the route in 27:16, write in 13, read in 12, debug in 11, cacheable in 10, privileged in 9, secure in 8 and the privilege ID in 7:0.
  - Data word 3 (0x38) holds the byte count in 9:0.
- R5: Bit 0 of the raw status register (0x50) is set by a captured null access whatever the enable. Bit 0 of the enabled status register (0x54) reads raw AND enable, and `irq` equals that bit.
- R6: Writing 1 to bit 0 at 0x58 sets the enable, and writing 1 to bit 0 at 0x5C clears it. Writing 0 to either has no effect. Both offsets read the enable in bit 0.
- R7: While an error is pending, further null accesses change neither the log nor the status.
- R8: Any write to the end-of-interrupt register (0x60) clears raw status, so the next null access is captured. Bits 15:0 of that register read back the last value written.
- R9: Writing 1 to bit 0 of the enabled status register clears raw status, and with it the enabled status and `irq`. Writing 0 has no effect. The log contents are kept.
- R10: Writing 1 to bit 0 of the raw status register sets raw status without touching the log. Writing 0 has no effect.
- R11: Header word 1 (0x28) always reads zero, meaning group 0 and code 0 (decode error). Offsets outside the map read zero.
- R12: The destination value in header word 0 is the one captured with the error. Later writes to the destination register do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld | input | 1 | One-cycle strobe marking a null access |
| err_addr | input | 48 | Address of the failing access |
| err_route | input | 12 | Route identifier of the initiator |
| err_wr | input | 1 | Access was a write |
| err_rd | input | 1 | Access was a read |
| err_dbg | input | 1 | Access was a debug access |
| err_cache | input | 1 | Access was cacheable |
| err_priv | input | 1 | Access was privileged |
| err_sec | input | 1 | Access was secure |
| err_priv_id | input | 8 | Privilege identity of the initiator |
| err_bytes | input | 10 | Byte count of the access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 48-bit error address and an 8-bit register offset. With an 8-bit offset it can reach every mapped register from 0x00 to 0x60, and also holes inside the map (0x08, 0x40) and at its top (0xFC), which must read as zero.

The default widths put the address split at bit 32. Using address values whose upper and lower halves differ shows whether the 16-bit upper part lands in data word 1.

The directed scenarios cover three orderings:
- an error raised while the interrupt is disabled and then enabled;
- a second error hitting a frozen log;
- recovery through end-of-interrupt versus through the status-clear write, followed by a software-set raw status.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

  localparam int REG_DW    = 32;
  localparam int ADDR_W    = 48;
  localparam int ADDR_LO_W = 32;
  localparam int ADDR_HI_W = ADDR_W - ADDR_LO_W;
  localparam int ROUTE_W   = 12;
  localparam int PRIV_ID_W = 8;
  localparam int BCNT_W    = 10;
  localparam int DEST_W    = 8;
  localparam int EOI_W     = 16;
  localparam int OFS_W     = 8;

  localparam logic [7:0] ERR_TYPE_NULL   = 8'd7;
  localparam logic [7:0] ERR_CODE_DECODE = 8'd0;
  localparam logic [7:0] ERR_GROUP       = 8'd0;

  localparam logic [OFS_W-1:0] OFS_REV     = 8'h00;
  localparam logic [OFS_W-1:0] OFS_DEST    = 8'h04;
  localparam logic [OFS_W-1:0] OFS_HDR0    = 8'h24;
  localparam logic [OFS_W-1:0] OFS_HDR1    = 8'h28;
  localparam logic [OFS_W-1:0] OFS_DAT0    = 8'h2C;
  localparam logic [OFS_W-1:0] OFS_DAT1    = 8'h30;
  localparam logic [OFS_W-1:0] OFS_DAT2    = 8'h34;
  localparam logic [OFS_W-1:0] OFS_DAT3    = 8'h38;
  localparam logic [OFS_W-1:0] OFS_RAW     = 8'h50;
  localparam logic [OFS_W-1:0] OFS_ENSTAT  = 8'h54;
  localparam logic [OFS_W-1:0] OFS_EN_SET  = 8'h58;
  localparam logic [OFS_W-1:0] OFS_EN_CLR  = 8'h5C;
  localparam logic [OFS_W-1:0] OFS_EOI     = 8'h60;

  typedef struct packed {
    logic [ADDR_W-1:0]    addr;
    logic [ROUTE_W-1:0]   route;
    logic                 wr;
    logic                 rd;
    logic                 dbg;
    logic                 cache;
    logic                 priv;
    logic                 sec;
    logic [PRIV_ID_W-1:0] priv_id;
    logic [BCNT_W-1:0]    bcnt;
  } txn_attr_t;

  typedef struct packed {
    logic dest;
    logic raw_set;
    logic stat_clr;
    logic en_set;
    logic en_clr;
    logic eoi;
  } wr_strobe_t;

  function automatic logic [REG_DW-1:0] rev_word();
    logic [REG_DW-1:0] w;
    w        = '0;
    w[31:30] = 2'd1;
    w[29:28] = 2'd2;
    w[27:16] = 12'h600;
    w[15:11] = 5'd6;
    w[10:8]  = 3'd1;
    w[7:6]   = 2'd0;
    w[5:0]   = 6'd2;
    return w;
  endfunction

  function automatic logic [REG_DW-1:0] hdr0_word(input logic [7:0] typ,
                                                  input logic [DEST_W-1:0] dest);
    logic [REG_DW-1:0] w;
    w        = '0;
    w[31:24] = typ;
    w[7:0]   = dest;
    return w;
  endfunction

  function automatic logic [REG_DW-1:0] hdr1_word();
    logic [REG_DW-1:0] w;
    w        = '0;
    w[31:24] = ERR_GROUP;
    w[23:16] = ERR_CODE_DECODE;
    return w;
  endfunction

  function automatic logic [REG_DW-1:0] dat0_word(input txn_attr_t a);
    return a.addr[ADDR_LO_W-1:0];
  endfunction

  function automatic logic [REG_DW-1:0] dat1_word(input txn_attr_t a);
    logic [REG_DW-1:0] w;
    w                = '0;
    w[ADDR_HI_W-1:0] = a.addr[ADDR_W-1:ADDR_LO_W];
    return w;
  endfunction

  function automatic logic [REG_DW-1:0] dat2_word(input txn_attr_t a);
    logic [REG_DW-1:0] w;
    w        = '0;
    w[27:16] = a.route;
    w[13]    = a.wr;
    w[12]    = a.rd;
    w[11]    = a.dbg;
    w[10]    = a.cache;
    w[9]     = a.priv;
    w[8]     = a.sec;
    w[7:0]   = a.priv_id;
    return w;
  endfunction

  function automatic logic [REG_DW-1:0] dat3_word(input txn_attr_t a);
    logic [REG_DW-1:0] w;
    w             = '0;
    w[BCNT_W-1:0] = a.bcnt;
    return w;
  endfunction

endpackage

// File: rtl/errlog_capture.sv
module errlog_capture
  import errlog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_vld,
  input  txn_attr_t         err_attr,
  input  logic              frozen,
  input  logic [DEST_W-1:0] dest_id,
  output logic              capture,
  output txn_attr_t         log_attr,
  output logic [7:0]        log_type,
  output logic [DEST_W-1:0] log_dest
);

  assign capture = err_vld & ~frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_attr <= '0;
      log_type <= '0;
      log_dest <= '0;
    end else if (capture) begin
      log_attr <= err_attr;
      log_type <= ERR_TYPE_NULL;
      log_dest <= dest_id;
    end
  end

  // R4
  capture_sets_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (log_type == ERR_TYPE_NULL));

endmodule

// File: rtl/errlog_irq_ctrl.sv
module errlog_irq_ctrl
  import errlog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  wr_strobe_t wstb,
  input  logic       wbit0,
  output logic       raw_q,
  output logic       en_q,
  output logic       irq
);

  logic raw_set_ev;
  logic raw_clr_ev;
  logic en_set_ev;
  logic en_clr_ev;

  assign raw_set_ev = capture | (wstb.raw_set & wbit0);
  assign raw_clr_ev = wstb.eoi | (wstb.stat_clr & wbit0);
  assign en_set_ev  = wstb.en_set & wbit0;
  assign en_clr_ev  = wstb.en_clr & wbit0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (raw_set_ev) begin
      raw_q <= 1'b1;
    end else if (raw_clr_ev) begin
      raw_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_set_ev) begin
      en_q <= 1'b1;
    end else if (en_clr_ev) begin
      en_q <= 1'b0;
    end
  end

  assign irq = raw_q & en_q;

  // R5
  capture_raises_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> raw_q);

  // R6
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb.en_set && wbit0) |=> en_q);

  // R6
  enable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb.en_clr && wbit0 && !wstb.en_set) |=> !en_q);

  // R8
  eoi_clears_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb.eoi && !capture) |=> !raw_q);

endmodule

// File: rtl/errlog_regfile.sv
module errlog_regfile
  import errlog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              raw_q,
  input  logic              en_q,
  input  txn_attr_t         log_attr,
  input  logic [7:0]        log_type,
  input  logic [DEST_W-1:0] log_dest,
  output logic [REG_DW-1:0] reg_rdata,
  output wr_strobe_t        wstb,
  output logic              wbit0,
  output logic [DEST_W-1:0] dest_q
);

  logic [EOI_W-1:0] eoi_q;
  logic [REG_DW-1:0] wdata_unused;

  assign wdata_unused = reg_wdata;
  assign wbit0        = reg_wdata[0];

  always_comb begin
    wstb          = '0;
    wstb.dest     = reg_wr && (reg_addr == OFS_DEST);
    wstb.raw_set  = reg_wr && (reg_addr == OFS_RAW);
    wstb.stat_clr = reg_wr && (reg_addr == OFS_ENSTAT);
    wstb.en_set   = reg_wr && (reg_addr == OFS_EN_SET);
    wstb.en_clr   = reg_wr && (reg_addr == OFS_EN_CLR);
    wstb.eoi      = reg_wr && (reg_addr == OFS_EOI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (wstb.dest) begin
      dest_q <= reg_wdata[DEST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_q <= '0;
    end else if (wstb.eoi) begin
      eoi_q <= reg_wdata[EOI_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_REV:    reg_rdata = rev_word();
      OFS_DEST:   reg_rdata[DEST_W-1:0] = dest_q;
      OFS_HDR0:   reg_rdata = hdr0_word(log_type, log_dest);
      OFS_HDR1:   reg_rdata = hdr1_word();
      OFS_DAT0:   reg_rdata = dat0_word(log_attr);
      OFS_DAT1:   reg_rdata = dat1_word(log_attr);
      OFS_DAT2:   reg_rdata = dat2_word(log_attr);
      OFS_DAT3:   reg_rdata = dat3_word(log_attr);
      OFS_RAW:    reg_rdata[0] = raw_q;
      OFS_ENSTAT: reg_rdata[0] = raw_q & en_q;
      OFS_EN_SET: reg_rdata[0] = en_q;
      OFS_EN_CLR: reg_rdata[0] = en_q;
      OFS_EOI:    reg_rdata[EOI_W-1:0] = eoi_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R3
  dest_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.dest |=> (dest_q == $past(reg_wdata[DEST_W-1:0])));

  // R1
  rev_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_REV) |-> (reg_rdata == 32'h6600_3102));

endmodule

// File: rtl/nullacc_err_logger.sv
module nullacc_err_logger
  import errlog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_vld,
  input  logic [47:0]       err_addr,
  input  logic [11:0]       err_route,
  input  logic              err_wr,
  input  logic              err_rd,
  input  logic              err_dbg,
  input  logic              err_cache,
  input  logic              err_priv,
  input  logic              err_sec,
  input  logic [7:0]        err_priv_id,
  input  logic [9:0]        err_bytes,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  txn_attr_t         in_attr;
  txn_attr_t         log_attr;
  logic [7:0]        log_type;
  logic [DEST_W-1:0] log_dest;
  logic [DEST_W-1:0] dest_q;
  logic              capture;
  logic              raw_q;
  logic              en_q;
  wr_strobe_t        wstb;
  logic              wbit0;

  always_comb begin
    in_attr         = '0;
    in_attr.addr    = err_addr;
    in_attr.route   = err_route;
    in_attr.wr      = err_wr;
    in_attr.rd      = err_rd;
    in_attr.dbg     = err_dbg;
    in_attr.cache   = err_cache;
    in_attr.priv    = err_priv;
    in_attr.sec     = err_sec;
    in_attr.priv_id = err_priv_id;
    in_attr.bcnt    = err_bytes;
  end

  errlog_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_vld  (err_vld),
    .err_attr (in_attr),
    .frozen   (raw_q),
    .dest_id  (dest_q),
    .capture  (capture),
    .log_attr (log_attr),
    .log_type (log_type),
    .log_dest (log_dest)
  );

  errlog_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .wstb    (wstb),
    .wbit0   (wbit0),
    .raw_q   (raw_q),
    .en_q    (en_q),
    .irq     (irq)
  );

  errlog_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .raw_q     (raw_q),
    .en_q      (en_q),
    .log_attr  (log_attr),
    .log_type  (log_type),
    .log_dest  (log_dest),
    .reg_rdata (reg_rdata),
    .wstb      (wstb),
    .wbit0     (wbit0),
    .dest_q    (dest_q)
  );

  // R7
  frozen_log_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q |=> ($stable(log_attr) && $stable(log_dest)));

endmodule

// File: tb/tb_nullacc_err_logger.sv
module tb_nullacc_err_logger;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_vld = 1'b0;
  logic [47:0] err_addr = '0;
  logic [11:0] err_route = '0;
  logic        err_wr = 1'b0, err_rd = 1'b0, err_dbg = 1'b0;
  logic        err_cache = 1'b0, err_priv = 1'b0, err_sec = 1'b0;
  logic [7:0]  err_priv_id = '0;
  logic [9:0]  err_bytes = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nullacc_err_logger dut (
    .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_addr(err_addr),
    .err_route(err_route), .err_wr(err_wr), .err_rd(err_rd), .err_dbg(err_dbg),
    .err_cache(err_cache), .err_priv(err_priv), .err_sec(err_sec),
    .err_priv_id(err_priv_id), .err_bytes(err_bytes), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  // flags order: wr, rd, dbg, cache, priv, sec
  task automatic send_err(input logic [47:0] a, input logic [11:0] rt,
                          input logic [5:0] fl, input logic [7:0] pid,
                          input logic [9:0] bc);
    @(negedge clk);
    err_addr = a; err_route = rt;
    {err_wr, err_rd, err_dbg, err_cache, err_priv, err_sec} = fl;
    err_priv_id = pid; err_bytes = bc; err_vld = 1'b1;
    @(negedge clk);
    err_vld = 1'b0;
    err_addr = '0; err_route = '0; err_priv_id = '0; err_bytes = '0;
    {err_wr, err_rd, err_dbg, err_cache, err_priv, err_sec} = '0;
  endtask

  function automatic logic [31:0] exp_d2(input logic [11:0] rt, input logic [5:0] fl,
                                         input logic [7:0] pid);
    return (32'(rt) << 16) | (32'(fl) << 8) | 32'(pid);
  endfunction

  task automatic t_reset();
    check("R2 irq after reset", 32'(irq), 0);
    chk_reg("R2 dest", 8'h04, 0);
    chk_reg("R2 hdr0", 8'h24, 0);
    chk_reg("R2 dat0", 8'h2C, 0);
    chk_reg("R2 dat2", 8'h34, 0);
    chk_reg("R2 raw", 8'h50, 0);
    chk_reg("R2 ensel", 8'h58, 0);
    chk_reg("R2 eoi", 8'h60, 0);
  endtask

  task automatic t_revision();
    chk_reg("R1 rev", 8'h00, 32'h6600_3102);
    wr(8'h00, 32'h0);
    chk_reg("R1 rev after write", 8'h00, 32'h6600_3102);
  endtask

  task automatic t_dest();
    wr(8'h04, 32'hFFFF_FFAB);
    chk_reg("R3 dest readback", 8'h04, 32'h0000_00AB);
  endtask

  task automatic t_capture_disabled();
    send_err(48'hA5C3_1234_5678, 12'hABC, 6'b101010, 8'h5D, 10'h3FF);
    chk_reg("R5 raw set while disabled", 8'h50, 1);
    chk_reg("R5 enabled status gated", 8'h54, 0);
    check("R5 irq low while disabled", 32'(irq), 0);
    chk_reg("R4 hdr0", 8'h24, 32'h0700_00AB);
    chk_reg("R4 dat0", 8'h2C, 32'h1234_5678);
    chk_reg("R4 dat1", 8'h30, 32'h0000_A5C3);
    chk_reg("R4 dat2", 8'h34, exp_d2(12'hABC, 6'b101010, 8'h5D));
    chk_reg("R4 dat3", 8'h38, 32'h0000_03FF);
  endtask

  task automatic t_enable();
    wr(8'h58, 32'hFFFF_FFFE);
    chk_reg("R6 set write 0 no effect", 8'h58, 0);
    wr(8'h58, 32'h1);
    chk_reg("R6 set reads at 0x58", 8'h58, 1);
    chk_reg("R6 set reads at 0x5C", 8'h5C, 1);
    chk_reg("R5 enabled status", 8'h54, 1);
    check("R5 irq follows enable", 32'(irq), 1);
    wr(8'h5C, 32'h0);
    chk_reg("R6 clr write 0 no effect", 8'h5C, 1);
    wr(8'h5C, 32'h1);
    chk_reg("R6 clr", 8'h58, 0);
    check("R6 irq drops on disable", 32'(irq), 0);
    chk_reg("R5 raw kept while disabled", 8'h50, 1);
    wr(8'h58, 32'h1);
    check("R6 irq back on enable", 32'(irq), 1);
  endtask

  task automatic t_freeze();
    send_err(48'h0000_DEAD_BEEF, 12'h001, 6'b010001, 8'h01, 10'h004);
    chk_reg("R7 dat0 frozen", 8'h2C, 32'h1234_5678);
    chk_reg("R7 dat2 frozen", 8'h34, exp_d2(12'hABC, 6'b101010, 8'h5D));
    check("R7 irq still high", 32'(irq), 1);
  endtask

  task automatic t_dest_snapshot();
    wr(8'h04, 32'h11);
    chk_reg("R12 hdr0 keeps captured dest", 8'h24, 32'h0700_00AB);
  endtask

  task automatic t_eoi();
    wr(8'h60, 32'hCAFE_BEEF);
    chk_reg("R8 eoi readback", 8'h60, 32'h0000_BEEF);
    chk_reg("R8 raw cleared", 8'h50, 0);
    check("R8 irq cleared", 32'(irq), 0);
    send_err(48'h7777_0000_0040, 12'h123, 6'b000111, 8'hC4, 10'h010);
    chk_reg("R8 next error dat0", 8'h2C, 32'h0000_0040);
    chk_reg("R8 next error dat1", 8'h30, 32'h0000_7777);
    chk_reg("R8 next error hdr0", 8'h24, 32'h0700_0011);
    chk_reg("R8 next error dat2", 8'h34, exp_d2(12'h123, 6'b000111, 8'hC4));
    check("R8 irq for next error", 32'(irq), 1);
  endtask

  task automatic t_stat_clear();
    wr(8'h54, 32'hFFFF_FFFE);
    chk_reg("R9 write 0 no effect", 8'h50, 1);
    wr(8'h54, 32'h1);
    chk_reg("R9 raw cleared", 8'h50, 0);
    chk_reg("R9 enabled status cleared", 8'h54, 0);
    check("R9 irq cleared", 32'(irq), 0);
    chk_reg("R9 log kept", 8'h2C, 32'h0000_0040);
  endtask

  task automatic t_raw_set();
    wr(8'h50, 32'h0);
    chk_reg("R10 write 0 no effect", 8'h50, 0);
    wr(8'h50, 32'h1);
    chk_reg("R10 raw set by software", 8'h50, 1);
    check("R10 irq from software set", 32'(irq), 1);
    chk_reg("R10 log untouched", 8'h30, 32'h0000_7777);
    wr(8'h60, 32'h0);
    chk_reg("R8 eoi clears software raw", 8'h50, 0);
  endtask

  task automatic t_unmapped();
    chk_reg("R11 hdr1", 8'h28, 0);
    chk_reg("R11 hole 0x08", 8'h08, 0);
    chk_reg("R11 hole 0x40", 8'h40, 0);
    chk_reg("R11 top 0xFC", 8'hFC, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_revision();
    t_dest();
    t_capture_disabled();
    t_enable();
    t_freeze();
    t_dest_snapshot();
    t_eoi();
    t_stat_clear();
    t_raw_set();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule